// File: doc/BRIEF.md
# Auxiliary Memory Bank Routing Switches

This block is the soft-switch register set that sits beside the CPU of an 8-bit machine with a 16-bit address bus. The machine has two 64 KB RAM banks, main and auxiliary. For every bus access the block tells the memory system which of the two banks should answer. It gives one select for the read path and one for the write path. It also holds the display-mode flags and the keyboard latch, and it returns a status byte whenever the CPU reads one of the flag-status locations.

Switch locations in page $C0 are decoded from the address together with the read and write strobes. A flag changes at the clock edge that ends the access. The two bank selects come straight from the current flags and the current address, with no register in between. Because of this, a switch access changes routing from the next bus cycle onward.

Zero page and stack have one flag of their own. The general RAM area follows separate read-bank and write-bank flags. The text window and the hi-res window can be taken over by a store-override flag. While that flag is set, the page-select flag routes both windows, for reads and for writes alike.

Top module: `aux_bank_router`

## Requirements
- R1: After reset every flag is 0 and the key-down latch is clear. Every access routes to main RAM (selects low), and every flag-status read returns 0x00.
- R2: A write to $C000–$C00F changes one flag, chosen by address bits 3:1. Index 0 is store-override (mode_flags bit 0), 1 is read-aux (bit 1), 2 is write-aux (bit 2), 3 is internal-slot-ROM (bit 3), 4 is alt-zero-page (bit 4), 5 is slot-3-ROM (bit 5), 6 is 80-column (bit 6) and 7 is alt-charset (bit 7). An odd address sets the flag and an even address clears it. A read of these addresses changes no flag.
- R3: The internal-slot-ROM flag is the exception to R2. It is set by the even address $C006 and cleared by the odd address $C007.
- R4: A read of $C013–$C01F returns one flag in bit 7, with bits 6:0 at zero. In address order the flags are: read-aux, write-aux, internal-slot-ROM, alt-zero-page, slot-3-ROM, store-override, the vbl_in input, text, mixed, page2, hires, alt-charset, 80-column. $C011, $C012 and all other non-keyboard addresses read 0x00.
- R5: Reads and writes in $0000–$01FF select auxiliary RAM exactly when alt-zero-page is set.
- R6: In $0200–$BFFF, reads select auxiliary RAM when read-aux is set and writes select it when write-aux is set. From $C000 upward both selects are low.
- R7: While store-override is set, reads and writes in $0400–$07FF and $2000–$3FFF select auxiliary RAM exactly when page2 is set. Read-aux and write-aux have no effect there.
- R8: While store-override is clear, the windows of R7 follow read-aux for reads and write-aux for writes.
- R9: Any read or write of $C050–$C057 sets a display flag to address bit 0. $C050/1 drives text (bit 8), $C052/3 mixed (bit 9), $C054/5 page2 (bit 10) and $C056/7 hires (bit 11).
- R10: A key_press pulse latches key_code and sets key-down. A read of $C000–$C010 returns {key-down, key code}.
- R11: Any read or write of $C010 clears key-down, and so does a write to $C011–$C01F. A read of $C011–$C01F leaves it. A key_press in the same cycle as a clear wins.
- R12: A flag changes only at a clock edge where a strobe marks a matching switch access. The new value shows on the selects and on the status from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address of the current bus cycle |
| rd_stb | input | 1 | Read access this cycle |
| wr_stb | input | 1 | Write access this cycle |
| key_press | input | 1 | One-cycle pulse: a new key is available |
| key_code | input | 7 | Key code accompanying key_press |
| vbl_in | input | 1 | Vertical blank status shown by the status read |
| aux_rd_sel | output | 1 | Current read goes to auxiliary RAM |
| aux_wr_sel | output | 1 | Current write goes to auxiliary RAM |
| stat_data | output | 8 | Read data for keyboard and flag-status addresses |
| mode_flags | output | 12 | Stored flags, bit positions as in R2 and R9 |

## Verification
A flag register holding a wrong value shows up in two places. It appears on the matching status byte at once, and on the bank select of the next access into the region that flag governs. The bench compares the selects, the status byte and the flag vector against a behavioural model on every cycle. A stray or missed update is therefore seen in the cycle right after the faulty edge. Store-override is toggled against page2, read-aux and write-aux, so that a window which follows the wrong flag leads to a mismatch. The key latch is cleared from each of its clearing addresses and then read back through $C000, which exposes an ignored clear or an extra one.

// File: rtl/aux_pkg.sv
package aux_pkg;
  localparam int NFLAG   = 12;
  localparam int NPAIR   = 8;
  localparam int NVIDEO  = 4;
  // flag indices; 0..7 follow the pair order decoded from address bits 3:1
  localparam int F_STORE = 0;
  localparam int F_RDAUX = 1;
  localparam int F_WRAUX = 2;
  localparam int F_INTCX = 3;
  localparam int F_ALTZP = 4;
  localparam int F_C3ROM = 5;
  localparam int F_COL80 = 6;
  localparam int F_ALTCH = 7;
  localparam int F_TEXT  = 8;
  localparam int F_MIXED = 9;
  localparam int F_PAGE2 = 10;
  localparam int F_HIRES = 11;

  localparam logic [15:0] A_ZP_END   = 16'h01FF;
  localparam logic [15:0] A_TXT_LO   = 16'h0400;
  localparam logic [15:0] A_TXT_HI   = 16'h07FF;
  localparam logic [15:0] A_HGR_LO   = 16'h2000;
  localparam logic [15:0] A_HGR_HI   = 16'h3FFF;
  localparam logic [15:0] A_IO_BASE  = 16'hC000;
  localparam logic [15:0] A_KEYCLR   = 16'hC010;
  localparam logic [11:0] A_PAIR_PG  = 12'hC00;  // $C000-$C00F
  localparam logic [11:0] A_STAT_PG  = 12'hC01;  // $C010-$C01F
  localparam logic [12:0] A_VID_PG   = 13'h180A; // $C050-$C057

  function automatic logic in_win(input logic [15:0] a, input logic [15:0] lo,
                                  input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/aux_switch_decode.sv
module aux_switch_decode
  import aux_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic [NFLAG-1:0]  flag_set,
  output logic [NFLAG-1:0]  flag_clr,
  output logic              key_clr
);
  logic pair_hit;
  logic vid_hit;
  logic any_acc;

  assign any_acc  = rd | wr;
  assign pair_hit = wr && (addr[15:4] == A_PAIR_PG);
  assign vid_hit  = any_acc && (addr[15:3] == A_VID_PG);

  genvar gi;
  generate
    for (gi = 0; gi < NPAIR; gi++) begin : g_pair
      localparam logic INV = (gi == F_INTCX);
      logic sel;
      assign sel = pair_hit && (addr[3:1] == 3'(gi));
      assign flag_set[gi] = sel && (addr[0] ^ INV);
      assign flag_clr[gi] = sel && !(addr[0] ^ INV);
    end
    for (gi = 0; gi < NVIDEO; gi++) begin : g_video
      logic sel;
      assign sel = vid_hit && (addr[2:1] == 2'(gi));
      assign flag_set[NPAIR+gi] = sel && addr[0];
      assign flag_clr[NPAIR+gi] = sel && !addr[0];
    end
  endgenerate

  assign key_clr = (any_acc && (addr == A_KEYCLR)) ||
                   (wr && (addr[15:4] == A_STAT_PG) && (addr[3:0] != 4'h0));
endmodule

// File: rtl/aux_flag_regs.sv
module aux_flag_regs
  import aux_pkg::*;
#(
  parameter int KEY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flag_set,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic             key_clr,
  input  logic             key_press,
  input  logic [KEY_W-1:0] key_code,
  output logic [NFLAG-1:0] flags,
  output logic             key_down,
  output logic [KEY_W-1:0] key_val
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [NFLAG-1:0] flags_nxt;
  logic             flags_en;
  logic             kd_nxt;
  logic             kd_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    flags_en  = |(flag_set | flag_clr);
    flags_nxt = (flags | flag_set) & ~flag_clr;
    kd_en     = key_press | key_clr;
    kd_nxt    = key_press ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    flags <= '0;
    else if (flags_en) flags <= flags_nxt;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) key_down <= 1'b0;
    else if (kd_en) key_down <= kd_nxt;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)     key_val <= '0;
    else if (key_press) key_val <= key_code;
  end
endmodule

// File: rtl/aux_bank_route.sv
module aux_bank_route
  import aux_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NFLAG-1:0]  flags,
  output logic              rd_aux,
  output logic              wr_aux
);
  logic in_zp;
  logic in_disp;
  logic in_io;

  always_comb begin
    in_zp   = (addr <= A_ZP_END);
    in_io   = (addr >= A_IO_BASE);
    in_disp = in_win(addr, A_TXT_LO, A_TXT_HI) || in_win(addr, A_HGR_LO, A_HGR_HI);
    if (in_zp) begin
      rd_aux = flags[F_ALTZP];
      wr_aux = flags[F_ALTZP];
    end else if (in_io) begin
      rd_aux = 1'b0;
      wr_aux = 1'b0;
    end else if (in_disp && flags[F_STORE]) begin
      rd_aux = flags[F_PAGE2];
      wr_aux = flags[F_PAGE2];
    end else begin
      rd_aux = flags[F_RDAUX];
      wr_aux = flags[F_WRAUX];
    end
  end
endmodule

// File: rtl/aux_status_mux.sv
module aux_status_mux
  import aux_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int KEY_W  = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NFLAG-1:0]  flags,
  input  logic              vbl,
  input  logic              key_down,
  input  logic [KEY_W-1:0]  key_val,
  output logic [7:0]        data
);
  logic bit7;

  always_comb begin
    bit7 = 1'b0;
    case (addr[3:0])
      4'h3: bit7 = flags[F_RDAUX];
      4'h4: bit7 = flags[F_WRAUX];
      4'h5: bit7 = flags[F_INTCX];
      4'h6: bit7 = flags[F_ALTZP];
      4'h7: bit7 = flags[F_C3ROM];
      4'h8: bit7 = flags[F_STORE];
      4'h9: bit7 = vbl;
      4'hA: bit7 = flags[F_TEXT];
      4'hB: bit7 = flags[F_MIXED];
      4'hC: bit7 = flags[F_PAGE2];
      4'hD: bit7 = flags[F_HIRES];
      4'hE: bit7 = flags[F_ALTCH];
      4'hF: bit7 = flags[F_COL80];
      default: bit7 = 1'b0;
    endcase
    if (addr[15:4] == A_PAIR_PG || addr == A_KEYCLR)
      data = {key_down, 7'(key_val)};
    else if (addr[15:4] == A_STAT_PG)
      data = {bit7, 7'b0};
    else
      data = 8'h00;
  end
endmodule

// File: rtl/aux_bank_router.sv
module aux_bank_router
  import aux_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int KEY_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              key_press,
  input  logic [KEY_W-1:0]  key_code,
  input  logic              vbl_in,
  output logic              aux_rd_sel,
  output logic              aux_wr_sel,
  output logic [7:0]        stat_data,
  output logic [NFLAG-1:0]  mode_flags
);
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;
  logic             key_clr;
  logic             key_down;
  logic [KEY_W-1:0] key_val;

  aux_switch_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(cpu_addr), .rd(rd_stb), .wr(wr_stb),
    .flag_set(flag_set), .flag_clr(flag_clr), .key_clr(key_clr)
  );

  aux_flag_regs #(.KEY_W(KEY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .flag_clr(flag_clr),
    .key_clr(key_clr), .key_press(key_press), .key_code(key_code),
    .flags(mode_flags), .key_down(key_down), .key_val(key_val)
  );

  aux_bank_route #(.ADDR_W(ADDR_W)) u_route (
    .addr(cpu_addr), .flags(mode_flags), .rd_aux(aux_rd_sel), .wr_aux(aux_wr_sel)
  );

  aux_status_mux #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_stat (
    .addr(cpu_addr), .flags(mode_flags), .vbl(vbl_in), .key_down(key_down),
    .key_val(key_val), .data(stat_data)
  );
endmodule

// File: rtl/aux_bank_router_chk.sv
module aux_bank_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        rd_stb,
  input logic        wr_stb,
  input logic        aux_rd_sel,
  input logic        aux_wr_sel,
  input logic [7:0]  stat_data,
  input logic [11:0] mode_flags
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode_flags == 12'h000));

  assert_rdaux_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cpu_addr == 16'hC003) |=> mode_flags[1]);

  assert_intcx_inverted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cpu_addr == 16'hC006) |=> mode_flags[3]);

  assert_stat_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:4] == 12'hC01 && cpu_addr[3:0] != 4'h0) |-> (stat_data[6:0] == 7'h00));

  assert_zp_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr <= 16'h01FF) |-> (aux_rd_sel == mode_flags[4] && aux_wr_sel == mode_flags[4]));

  assert_io_main_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= 16'hC000) |-> (!aux_rd_sel && !aux_wr_sel));

  assert_store_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_flags[0] && cpu_addr >= 16'h0400 && cpu_addr <= 16'h07FF)
      |-> (aux_rd_sel == mode_flags[10] && aux_wr_sel == mode_flags[10]));

  assert_page2_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb || wr_stb) && cpu_addr == 16'hC055) |=> mode_flags[10]);

  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !wr_stb) |=> $stable(mode_flags));
endmodule

bind aux_bank_router aux_bank_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .aux_rd_sel(aux_rd_sel), .aux_wr_sel(aux_wr_sel), .stat_data(stat_data),
  .mode_flags(mode_flags)
);

// File: tb/aux_bank_router_tb.sv
`timescale 1ns/1ps
module aux_bank_router_tb;
  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        rd_stb, wr_stb, key_press, vbl_in;
  logic [6:0]  key_code;
  logic        aux_rd_sel, aux_wr_sel;
  logic [7:0]  stat_data;
  logic [11:0] mode_flags;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural model state
  bit [11:0] m_fl;
  bit        m_kd;
  bit [6:0]  m_kc;

  aux_bank_router u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .key_press(key_press), .key_code(key_code), .vbl_in(vbl_in),
    .aux_rd_sel(aux_rd_sel), .aux_wr_sel(aux_wr_sel), .stat_data(stat_data),
    .mode_flags(mode_flags)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic bit m_route(input int a, input bit is_wr);
    if (a < 'h200) return m_fl[4];
    if (a >= 'hC000) return 0;
    if (((a >= 'h400 && a < 'h800) || (a >= 'h2000 && a < 'h4000)) && m_fl[0]) return m_fl[10];
    return is_wr ? m_fl[2] : m_fl[1];
  endfunction

  function automatic bit [7:0] m_stat(input int a);
    bit b;
    if (a >= 'hC000 && a <= 'hC010) return {m_kd, m_kc};
    if (a < 'hC011 || a > 'hC01F) return 8'h00;
    case (a)
      'hC013: b = m_fl[1];  'hC014: b = m_fl[2];  'hC015: b = m_fl[3];
      'hC016: b = m_fl[4];  'hC017: b = m_fl[5];  'hC018: b = m_fl[0];
      'hC019: b = vbl_in;   'hC01A: b = m_fl[8];  'hC01B: b = m_fl[9];
      'hC01C: b = m_fl[10]; 'hC01D: b = m_fl[11]; 'hC01E: b = m_fl[7];
      'hC01F: b = m_fl[6];  default: b = 0;
    endcase
    return {b, 7'h00};
  endfunction

  function automatic string region_tag(input int a);
    if (a < 'h200) return "R5";
    if ((a >= 'h400 && a < 'h800) || (a >= 'h2000 && a < 'h4000)) return m_fl[0] ? "R7" : "R8";
    if (a < 'hC000 || a >= 'hC100) return "R6";
    if (a <= 'hC010) return "R10";
    if (a <= 'hC01F) return "R4";
    return "R9";
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int a, input bit r, input bit w, input bit kp,
                      input bit [6:0] kv, input string tag);
    string t;
    int idx;
    bit clr;
    @(negedge clk);
    cpu_addr = a[15:0]; rd_stb = r; wr_stb = w; key_press = kp; key_code = kv;
    #1;
    t = (tag == "") ? region_tag(a) : tag;
    cmp(t, "aux_rd_sel", int'(aux_rd_sel), int'(m_route(a, 0)));
    cmp(t, "aux_wr_sel", int'(aux_wr_sel), int'(m_route(a, 1)));
    cmp(t, "stat_data", int'(stat_data), int'(m_stat(a)));
    cmp((tag == "") ? "R2" : tag, "mode_flags", int'(mode_flags), int'(m_fl));
    // model update for the coming edge
    if (w && a >= 'hC000 && a <= 'hC00F) begin
      idx = (a >> 1) & 7;
      m_fl[idx] = (idx == 3) ? !a[0] : a[0];
    end
    if ((r || w) && a >= 'hC050 && a <= 'hC057) m_fl[8 + ((a >> 1) & 3)] = a[0];
    clr = ((r || w) && a == 'hC010) || (w && a >= 'hC011 && a <= 'hC01F);
    if (kp) begin m_kd = 1; m_kc = kv; end
    else if (clr) m_kd = 0;
  endtask

  initial begin
    #900000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [31:0] lfsr;
    int a;
    int sel;
    rst_n = 0; cpu_addr = 0; rd_stb = 0; wr_stb = 0; key_press = 0; key_code = 0; vbl_in = 0;
    m_fl = '0; m_kd = 0; m_kc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    // R1 reset state
    step('h0300, 1, 0, 0, 0, "R1");
    step('h0000, 0, 1, 0, 0, "R1");
    step('hC018, 1, 0, 0, 0, "R1");
    step('hC000, 1, 0, 0, 0, "R1");
    // R2 / R12: set read-aux, then the next cycle routes aux
    step('hC003, 0, 1, 0, 0, "R2");
    step('h0300, 1, 0, 0, 0, "R12");
    step('hC002, 1, 0, 0, 0, "R2");   // read: no change
    step('hC013, 1, 0, 0, 0, "R2");
    // R3 inverted flag
    step('hC006, 0, 1, 0, 0, "R3");
    step('hC015, 1, 0, 0, 0, "R3");
    step('hC007, 0, 1, 0, 0, "R3");
    step('hC015, 1, 0, 0, 0, "R3");
    // R5 zero page
    step('hC009, 0, 1, 0, 0, "R5");
    step('h0100, 0, 1, 0, 0, "R5");
    step('hC008, 0, 1, 0, 0, "R5");
    step('h01FF, 1, 0, 0, 0, "R5");
    // R7 store-override with page2
    step('hC001, 0, 1, 0, 0, "R7");
    step('hC055, 1, 0, 0, 0, "R9");
    step('h0500, 1, 0, 0, 0, "R7");
    step('h2100, 0, 1, 0, 0, "R7");
    step('hC002, 0, 1, 0, 0, "R7");
    step('h0500, 1, 0, 0, 0, "R7");
    step('hC054, 0, 1, 0, 0, "R9");
    step('h3FFF, 0, 1, 0, 0, "R7");
    // R8 override off
    step('hC000, 0, 1, 0, 0, "R8");
    step('hC005, 0, 1, 0, 0, "R8");
    step('h0600, 0, 1, 0, 0, "R8");
    step('h2000, 1, 0, 0, 0, "R8");
    // R9 other display flags
    step('hC051, 1, 0, 0, 0, "R9");
    step('hC057, 0, 1, 0, 0, "R9");
    step('hC01A, 1, 0, 0, 0, "R9");
    // R10 keyboard latch
    step('h0000, 0, 0, 1, 7'h41, "R10");
    step('hC000, 1, 0, 0, 0, "R10");
    step('hC00F, 1, 0, 0, 0, "R10");
    // R11 clears
    step('hC011, 1, 0, 0, 0, "R11");
    step('hC000, 1, 0, 0, 0, "R11");
    step('hC015, 0, 1, 0, 0, "R11");
    step('hC000, 1, 0, 0, 0, "R11");
    step('h0000, 0, 0, 1, 7'h2A, "R11");
    step('hC010, 1, 0, 0, 0, "R11");
    step('hC000, 1, 0, 0, 0, "R11");
    step('hC010, 0, 1, 1, 7'h33, "R11");
    step('hC010, 1, 0, 0, 0, "R11");
    // R4 status sweep
    step('hC00B, 0, 1, 0, 0, "R4");
    vbl_in = 1;
    for (int i = 'hC011; i <= 'hC01F; i++) step(i, 1, 0, 0, 0, "R4");
    vbl_in = 0;
    // R6 upper area
    step('hC100, 1, 0, 0, 0, "R6");
    step('hFFFF, 0, 1, 0, 0, "R6");
    step('hBFFF, 0, 1, 0, 0, "R6");
    // pseudo-random mix
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 6000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sel = int'(lfsr[3:0]);
      if (sel < 5)       a = 'hC000 | int'(lfsr[23:20]);
      else if (sel < 7)  a = 'hC010 | int'(lfsr[23:20]);
      else if (sel < 9)  a = 'hC050 | int'(lfsr[22:20]);
      else if (sel < 11) a = ((lfsr[24]) ? 'h2000 : 'h0400) | int'(lfsr[29:20]);
      else               a = int'(lfsr[31:16]);
      vbl_in = lfsr[12];
      step(a, lfsr[5] & ~lfsr[6], lfsr[6], lfsr[9] & lfsr[10] & lfsr[11], lfsr[19:13], "");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule